// File: doc/BRIEF.md
# System Control Register Block with Selectable Map

This block holds a small set of memory-mapped system control registers behind a simple bus port. The port has an address, write data, and write and read strobes. The response comes back one cycle after the access: read data and an error flag. Its main job is holding CPUs in a wait state after reset. Software releases a CPU by clearing that CPU's wait bit. The block then emits a one-cycle release-and-reset pulse on the matching output line.

A static parameter picks one of two register maps. The legacy map keeps the CPU wait and NMI enable registers low in the window, with two wake-up control storage registers above them. The compact map moves CPU wait and NMI enable up into the wake-up slots and drops the wake-up registers. In the compact map the vacated low slots are reserved. The legacy map drives two CPUs. The compact map drives one.

Top module: `sysctl_unit`

## Requirements
- R1: With the legacy map, four registers are plain read/write storage: CPU wait at 0x118, NMI enable at 0x11C, wake-up interrupt control at 0x120 and external wake control at 0x124. A read returns the last value written, with the error flag low.
- R2: With the compact map, CPU wait sits at 0x120 and NMI enable at 0x124. Both are read/write with the error flag low.
- R3: With the compact map, any access to 0x118 or 0x11C returns read data 0 with the error flag high. A write there changes no register and produces no release pulse.
- R4: In either map, any other address returns read data 0 with the error flag high and changes no state. This includes unaligned addresses.
- R5: On an accepted write to CPU wait, every active bit that goes from 1 to 0 raises release output bit i for exactly one cycle. The pulse appears in the cycle after the write.
- R6: In the legacy map, bits 0 and 1 are active. In the compact map, only bit 0 is active, and release output bit 1 never pulses.
- R7: CPU wait stores the full 32-bit written value, including inactive bits, and reads return it unchanged.
- R8: After reset, CPU wait holds all active bits set: 0x3 in the legacy map and 0x1 in the compact map. All other registers read 0. While reset is held, read data, error flag and release outputs are 0.
- R9: Read data and the error flag are registered. They reflect an access in the cycle after it. Read data is 0 for writes, and both outputs are 0 in cycles with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data, one cycle after the access |
| err_o | output | 1 | Error response, one cycle after the access |
| release_o | output | N_CPU | Per-CPU release-and-reset pulses |

## Verification
A wrong wait-register value shows up in two ways at the ports. It can produce a release pulse that is missing or extra in the cycle after the next clearing write. It also appears directly on the read data one cycle after a read of that slot. A decoder mistake shows up in the first response cycle after the access, as a wrong error flag or nonzero data on a reserved or unmapped slot. A write that wrongly lands in storage is caught by reading the intended register afterwards. In the compact map, bit 1 of the wait value is cleared while its release line is watched, so a wrong active-CPU count is exposed in a single cycle.

// File: rtl/sysctl_unit_pkg.sv
package sysctl_unit_pkg;

  typedef enum logic {
    MAP_LEGACY  = 1'b0,
    MAP_COMPACT = 1'b1
  } map_e;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_RSVD = 3'd1,
    SEL_WAIT = 3'd2,
    SEL_NMI  = 3'd3,
    SEL_WIC  = 3'd4,
    SEL_EW   = 3'd5
  } sel_e;

  localparam logic [11:0] OFF_SLOT0 = 12'h118;
  localparam logic [11:0] OFF_SLOT1 = 12'h11C;
  localparam logic [11:0] OFF_SLOT2 = 12'h120;
  localparam logic [11:0] OFF_SLOT3 = 12'h124;

  function automatic int active_cpus(map_e m);
    return (m == MAP_LEGACY) ? 2 : 1;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_unit_pkg::*;
#(
  parameter map_e MAP    = MAP_LEGACY,
  parameter int   ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic              hit_o
);

  localparam logic [ADDR_W-1:0] A0 = ADDR_W'(OFF_SLOT0);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(OFF_SLOT1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(OFF_SLOT2);
  localparam logic [ADDR_W-1:0] A3 = ADDR_W'(OFF_SLOT3);

  generate
    if (MAP == MAP_LEGACY) begin : g_legacy
      always_comb begin
        unique case (addr_i)
          A0:      sel_o = SEL_WAIT;
          A1:      sel_o = SEL_NMI;
          A2:      sel_o = SEL_WIC;
          A3:      sel_o = SEL_EW;
          default: sel_o = SEL_NONE;
        endcase
      end
    end else begin : g_compact
      // low slots vacated, wait/nmi moved up
      always_comb begin
        unique case (addr_i)
          A0, A1:  sel_o = SEL_RSVD;
          A2:      sel_o = SEL_WAIT;
          A3:      sel_o = SEL_NMI;
          default: sel_o = SEL_NONE;
        endcase
      end
    end
  endgenerate

  assign hit_o = (sel_o != SEL_NONE) && (sel_o != SEL_RSVD);

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_unit_pkg::*;
#(
  parameter map_e MAP    = MAP_LEGACY,
  parameter int   DATA_W = 32,
  parameter int   N_CPU  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  sel_e              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_o,
  output logic [DATA_W-1:0] wait_o
);

  localparam int              ACTIVE   = active_cpus(MAP);
  localparam logic [DATA_W-1:0] WAIT_RST = DATA_W'((1 << ACTIVE) - 1);

  logic [DATA_W-1:0] wait_q, nmi_q, wic_q, ew_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         wait_q <= WAIT_RST;
    else if (wr_i && sel_i == SEL_WAIT)  wait_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         nmi_q <= '0;
    else if (wr_i && sel_i == SEL_NMI)   nmi_q <= wdata_i;
  end

  generate
    if (MAP == MAP_LEGACY) begin : g_wake
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       wic_q <= '0;
        else if (wr_i && sel_i == SEL_WIC) wic_q <= wdata_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       ew_q <= '0;
        else if (wr_i && sel_i == SEL_EW)  ew_q <= wdata_i;
      end
    end else begin : g_no_wake
      assign wic_q = '0;
      assign ew_q  = '0;
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      SEL_WAIT: rd_o = wait_q;
      SEL_NMI:  rd_o = nmi_q;
      SEL_WIC:  rd_o = wic_q;
      SEL_EW:   rd_o = ew_q;
      default:  rd_o = '0;
    endcase
  end

  assign wait_o = wait_q;

endmodule

// File: rtl/sysctl_release.sv
module sysctl_release #(
  parameter int N_CPU  = 2,
  parameter int ACTIVE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wait_wr_i,
  input  logic [N_CPU-1:0] cur_i,
  input  logic [N_CPU-1:0] nxt_i,
  output logic [N_CPU-1:0] pulse_o
);

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    if (g < ACTIVE) begin : g_act
      logic p_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= 1'b0;
        else         p_q <= wait_wr_i & cur_i[g] & ~nxt_i[g];
      end
      assign pulse_o[g] = p_q;
    end else begin : g_idle
      assign pulse_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
  import sysctl_unit_pkg::*;
#(
  parameter map_e MAP    = MAP_LEGACY,
  parameter int   ADDR_W = 12,
  parameter int   DATA_W = 32,
  parameter int   N_CPU  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [N_CPU-1:0]  release_o
);

  localparam int ACTIVE = active_cpus(MAP);

  sel_e              sel;
  logic              hit, wr_ok, wait_wr;
  logic [DATA_W-1:0] rd_val, wait_val;

  sysctl_decode #(.MAP(MAP), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  assign wr_ok   = we_i & hit;
  assign wait_wr = wr_ok & (sel == SEL_WAIT);

  sysctl_store #(.MAP(MAP), .DATA_W(DATA_W), .N_CPU(N_CPU)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ok),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .rd_o    (rd_val),
    .wait_o  (wait_val)
  );

  sysctl_release #(.N_CPU(N_CPU), .ACTIVE(ACTIVE)) u_rel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wait_wr_i (wait_wr),
    .cur_i     (wait_val[N_CPU-1:0]),
    .nxt_i     (wdata_i[N_CPU-1:0]),
    .pulse_o   (release_o)
  );

  // registered response; read returns pre-write value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= (re_i & hit) ? rd_val : '0;
      err_o   <= (we_i | re_i) & ~hit;
    end
  end

endmodule

// File: rtl/sysctl_unit_chk.sv
module sysctl_unit_chk
  import sysctl_unit_pkg::*;
#(
  parameter map_e MAP    = MAP_LEGACY,
  parameter int   ADDR_W = 12,
  parameter int   DATA_W = 32,
  parameter int   N_CPU  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic [N_CPU-1:0]  release_o
);

  localparam logic [ADDR_W-1:0] WAIT_A = (MAP == MAP_LEGACY) ? ADDR_W'(OFF_SLOT0) : ADDR_W'(OFF_SLOT2);

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  logic mapped;
  always_comb begin
    if (MAP == MAP_LEGACY)
      mapped = addr_i == ADDR_W'(OFF_SLOT0) || addr_i == ADDR_W'(OFF_SLOT1) ||
               addr_i == ADDR_W'(OFF_SLOT2) || addr_i == ADDR_W'(OFF_SLOT3);
    else
      mapped = addr_i == ADDR_W'(OFF_SLOT2) || addr_i == ADDR_W'(OFF_SLOT3);
  end

  assert_release_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && release_o != '0) |-> ($past(we_i) && $past(addr_i) == WAIT_A && !err_o));

  assert_release_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> ((release_o & $past(release_o)) == '0));

  assert_unmapped_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(we_i || re_i) && !$past(mapped)) |-> (err_o && rdata_o == '0));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(we_i || re_i)) |-> (!err_o && rdata_o == '0));

  assert_mapped_ok_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(we_i || re_i) && $past(mapped)) |-> !err_o);

  generate
    if (MAP == MAP_COMPACT && N_CPU > 1) begin : g_cmp
      assert_inactive_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        release_o[N_CPU-1:1] == '0);
      assert_reserved_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(we_i || re_i) &&
         ($past(addr_i) == ADDR_W'(OFF_SLOT0) || $past(addr_i) == ADDR_W'(OFF_SLOT1)))
        |-> (err_o && release_o == '0));
    end
  endgenerate

endmodule

bind sysctl_unit sysctl_unit_chk #(.MAP(MAP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CPU(N_CPU)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .re_i      (re_i),
  .rdata_o   (rdata_o),
  .err_o     (err_o),
  .release_o (release_o)
);

// File: tb/sysctl_unit_test.sv
`timescale 1ns/1ps
module sysctl_unit_test;
  import sysctl_unit_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [11:0] addr_a = '0, addr_b = '0;
  logic [31:0] wd_a = '0, wd_b = '0;
  logic        we_a = 1'b0, re_a = 1'b0, we_b = 1'b0, re_b = 1'b0;
  logic [31:0] rd_a, rd_b;
  logic        err_a, err_b;
  logic [1:0]  rel_a, rel_b;

  sysctl_unit #(.MAP(MAP_LEGACY)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_a), .wdata_i(wd_a),
    .we_i(we_a), .re_i(re_a), .rdata_o(rd_a), .err_o(err_a), .release_o(rel_a));

  sysctl_unit #(.MAP(MAP_COMPACT)) uut_b (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_b), .wdata_i(wd_b),
    .we_i(we_b), .re_i(re_b), .rdata_o(rd_b), .err_o(err_b), .release_o(rel_b));

  typedef struct {
    int          due;
    bit          d;
    logic [31:0] rd;
    bit          err;
    logic [1:0]  rel;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops the item due this cycle, else expects quiet outputs
  item_t it;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        it = q.pop_front();
        if (!it.d) begin
          chk(rd_a === it.rd, it.req, "rdata", rd_a, it.rd);
          chk(err_a === it.err, it.req, "err", 32'(err_a), 32'(it.err));
          chk(rel_a === it.rel, it.req, "release", 32'(rel_a), 32'(it.rel));
          chk(rel_b === 2'b00, it.req, "other release", 32'(rel_b), 32'h0);
        end else begin
          chk(rd_b === it.rd, it.req, "rdata", rd_b, it.rd);
          chk(err_b === it.err, it.req, "err", 32'(err_b), 32'(it.err));
          chk(rel_b === it.rel, it.req, "release", 32'(rel_b), 32'(it.rel));
          chk(rel_a === 2'b00, it.req, "other release", 32'(rel_a), 32'h0);
        end
      end else begin
        chk(rel_a === 2'b00 && rel_b === 2'b00, "R9", "idle release",
            {28'h0, rel_b, rel_a}, 32'h0);
        chk(!err_a && !err_b && rd_a === '0 && rd_b === '0, "R9", "idle response",
            rd_a | rd_b, 32'h0);
      end
    end
  end

  task automatic acc(input bit d, input bit w, input bit r, input logic [11:0] a,
                     input logic [31:0] wd, input logic [31:0] er, input bit ee,
                     input logic [1:0] erel, input string req);
    item_t n;
    we_a = 1'b0; re_a = 1'b0; we_b = 1'b0; re_b = 1'b0;
    if (!d) begin we_a = w; re_a = r; addr_a = a; wd_a = wd; end
    else    begin we_b = w; re_b = r; addr_b = a; wd_b = wd; end
    n.due = cyc + 1; n.d = d; n.rd = er; n.err = ee; n.rel = erel; n.req = req;
    q.push_back(n);
    @(negedge clk);
  endtask

  task automatic wr(input bit d, input logic [11:0] a, input logic [31:0] v,
                    input bit ee, input logic [1:0] erel, input string req);
    acc(d, 1'b1, 1'b0, a, v, 32'h0, ee, erel, req);
  endtask

  task automatic rd(input bit d, input logic [11:0] a, input logic [31:0] er,
                    input bit ee, input string req);
    acc(d, 1'b0, 1'b1, a, 32'h0, er, ee, 2'b00, req);
  endtask

  task automatic idle();
    we_a = 1'b0; re_a = 1'b0; we_b = 1'b0; re_b = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs quiet under reset
    chk(rd_a === '0 && rd_b === '0, "R8", "reset rdata", rd_a | rd_b, 32'h0);
    chk(!err_a && !err_b && rel_a === 2'b00 && rel_b === 2'b00, "R8", "reset flags",
        {28'h0, rel_b, rel_a}, 32'h0);
    rst_ni = 1'b1;
    idle();

    // legacy map
    rd(0, 12'h118, 32'h3, 0, "R8");
    rd(0, 12'h11C, 32'h0, 0, "R8");
    rd(0, 12'h120, 32'h0, 0, "R8");
    rd(0, 12'h124, 32'h0, 0, "R8");
    wr(0, 12'h11C, 32'hA5A5_0001, 0, 2'b00, "R1");
    rd(0, 12'h11C, 32'hA5A5_0001, 0, "R1");
    wr(0, 12'h120, 32'h0000_1234, 0, 2'b00, "R1");
    wr(0, 12'h124, 32'hFFFF_0000, 0, 2'b00, "R1");
    rd(0, 12'h120, 32'h0000_1234, 0, "R1");
    rd(0, 12'h124, 32'hFFFF_0000, 0, "R1");
    rd(0, 12'h200, 32'h0, 1, "R4");
    wr(0, 12'h200, 32'h1, 1, 2'b00, "R4");
    rd(0, 12'h128, 32'h0, 1, "R4");
    wr(0, 12'h11A, 32'h0, 1, 2'b00, "R4 unaligned");
    rd(0, 12'h118, 32'h3, 0, "R4 wait untouched");
    wr(0, 12'h118, 32'hF000_0002, 0, 2'b01, "R5 cpu0");
    wr(0, 12'h118, 32'hF000_0000, 0, 2'b10, "R5 cpu1");
    idle();
    rd(0, 12'h118, 32'hF000_0000, 0, "R7");
    wr(0, 12'h118, 32'h3, 0, 2'b00, "R5 set no pulse");
    wr(0, 12'h118, 32'h0, 0, 2'b11, "R6 both");
    wr(0, 12'h118, 32'h0, 0, 2'b00, "R5 no repeat");
    idle();

    // compact map
    rd(1, 12'h120, 32'h1, 0, "R8");
    rd(1, 12'h124, 32'h0, 0, "R8");
    rd(1, 12'h118, 32'h0, 1, "R3");
    wr(1, 12'h118, 32'h0, 1, 2'b00, "R3");
    rd(1, 12'h120, 32'h1, 0, "R3 wait untouched");
    wr(1, 12'h11C, 32'h5, 1, 2'b00, "R3");
    rd(1, 12'h124, 32'h0, 0, "R3 nmi untouched");
    wr(1, 12'h120, 32'hFFFF_FFFE, 0, 2'b01, "R5 compact");
    wr(1, 12'h120, 32'h0000_0002, 0, 2'b00, "R5 no pulse on 0");
    wr(1, 12'h120, 32'h0000_0000, 0, 2'b00, "R6 bit1 inactive");
    wr(1, 12'h120, 32'h0000_0006, 0, 2'b00, "R7");
    rd(1, 12'h120, 32'h0000_0006, 0, "R7");
    wr(1, 12'h120, 32'h3, 0, 2'b00, "R6");
    wr(1, 12'h120, 32'h0, 0, 2'b01, "R6 only cpu0");
    idle();
    wr(1, 12'h124, 32'h0000_CAFE, 0, 2'b00, "R2");
    rd(1, 12'h124, 32'h0000_CAFE, 0, "R2");
    rd(1, 12'h128, 32'h0, 1, "R4");
    idle();
    idle();

    chk(q.size() == 0, "R9", "pending responses", 32'(q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule